// File: doc/BRIEF.md
# Residue-Number Operand Sign and Magnitude Classifier

This block is the entry stage of a divider that works on numbers held in a residue number system. A dividend and a divisor each arrive as a vector of residues over fixed, pairwise coprime moduli. For each operand the block decides whether it lies in the negative half of the range and produces its magnitude. It also reports the sign of the quotient, and two early-exit flags: one says the quotient is zero, the other says the quotient is plus or minus one. A later iterative stage can skip its work when either flag is set.

All ordering decisions use a monotone core function. This is a weighted sum of the residues, and only its low bits are kept, so the core modulus is a power of two. The weights contain no negative terms and the range has no critical cores, so no positional reconstruction or rounding is needed. Two numbers with the same core value are ordered by their residue on one reference channel, which must carry a non-zero weight. The moduli, the core values of the orthogonal bases, the core value and reference residue of the range midpoint, and the reference channel are all elaboration-time parameters. The default set is the moduli 11, 13, 17 and 19, with a 17-bit core.

The result is registered once. It is captured only on cycles where `in_valid` is high, and `out_valid` marks the cycle after each capture.

Top module: `rns_sign_classifier`

## Requirements
- R1: The negation of an operand is formed per channel as modulus minus residue. A zero residue stays zero, so every magnitude residue is below its modulus.
- R2: `abs_dividend_core` equals the sum over channels of each magnitude residue times that channel's orthogonal-basis core value, kept modulo 2^CW. With the default set, this equals 16*floor(A/11)+8*floor(A/13)+5*floor(A/17)+9*floor(A/19) for magnitude A.
- R3: An operand of value X, in the range 0 to M-1 with M odd, is flagged negative (`dvd_neg`, `dvs_neg`) exactly when X > (M-1)/2.
- R4: `res_neg` is the exclusive OR of the two operand sign flags.
- R5: A non-negative operand passes through unchanged as its magnitude. A negative operand yields M-X. Channel i occupies bits [i*RW +: RW] of every residue vector, with channel 0 least significant.
- R6: `q_zero` is 1 exactly when the dividend magnitude is smaller than the divisor magnitude.
- R7: `q_unit` is 1 exactly when the two magnitudes are equal. `q_zero` and `q_unit` are never 1 together.
- R8: The results of an input accepted with `in_valid` high appear on the outputs after the next rising clock edge. `out_valid` is `in_valid` delayed by one cycle.
- R9: While `in_valid` is low, all result outputs hold their previous values, whatever the operand inputs do.
- R10: While `rst_n` is low, `out_valid`, `q_zero` and `q_unit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| dividend | input | NCH*RW | Dividend residues, channel 0 in the low bits |
| divisor | input | NCH*RW | Divisor residues, channel 0 in the low bits |
| out_valid | output | 1 | Registered results are fresh |
| res_neg | output | 1 | Quotient sign: 1 means negative |
| dvd_neg | output | 1 | Dividend is negative |
| dvs_neg | output | 1 | Divisor is negative |
| q_zero | output | 1 | Dividend magnitude is below divisor magnitude |
| q_unit | output | 1 | Magnitudes are equal |
| abs_dividend | output | NCH*RW | Dividend magnitude residues |
| abs_dividend_core | output | CW | Core value of the dividend magnitude |
| abs_divisor | output | NCH*RW | Divisor magnitude residues |

## Verification
Every integer of the default range is applied once as a dividend. Each is paired with a scrambled divisor, so both sides of the midpoint, the midpoint itself and values whose negation hits a zero residue all appear with both sign combinations. A second sweep builds pairs with equal magnitudes, including opposite-sign pairs whose residues differ, and pairs whose magnitudes differ by one in each direction. This separates a correct tie-break on the reference channel from a comparison that only looks at core values. A short idle stretch, with changing operands and `in_valid` low, shows that the registered results do not move.

// File: rtl/rns_sign_pkg.sv
package rns_sign_pkg;

  typedef enum logic [1:0] {
    ORD_LT = 2'd0,
    ORD_EQ = 2'd1,
    ORD_GT = 2'd2
  } ord_e;

endpackage

// File: rtl/rns_order_cmp.sv
// Orders two numbers by core value first; equal cores are settled by the
// residue of the reference channel.
module rns_order_cmp #(
  parameter int unsigned CW = 17,
  parameter int unsigned RW = 5
) (
  input  logic [CW-1:0]        a_core,
  input  logic [RW-1:0]        a_tie,
  input  logic [CW-1:0]        b_core,
  input  logic [RW-1:0]        b_tie,
  output rns_sign_pkg::ord_e   rel
);
  import rns_sign_pkg::*;

  always_comb begin
    if (a_core < b_core)      rel = ORD_LT;
    else if (a_core > b_core) rel = ORD_GT;
    else if (a_tie < b_tie)   rel = ORD_LT;
    else if (a_tie > b_tie)   rel = ORD_GT;
    else                      rel = ORD_EQ;
  end

endmodule

// File: rtl/rns_negate.sv
// Per-channel additive inverse; a zero residue maps to zero.
module rns_negate #(
  parameter int unsigned NCH = 4,
  parameter int unsigned RW  = 5,
  parameter int unsigned MODULI [NCH] = '{11, 13, 17, 19}
) (
  input  logic [NCH-1:0][RW-1:0] r,
  output logic [NCH-1:0][RW-1:0] neg
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [RW-1:0] MOD_C = RW'(MODULI[ch]);
    assign neg[ch] = (r[ch] == '0) ? '0 : MOD_C - r[ch];
  end

endmodule

// File: rtl/rns_core_eval.sv
// Core value: weighted residue sum, truncated to CW bits.
module rns_core_eval #(
  parameter int unsigned NCH = 4,
  parameter int unsigned RW  = 5,
  parameter int unsigned CW  = 17,
  parameter int unsigned BASIS_CORE [NCH] = '{83408, 100824, 84811, 124173}
) (
  input  logic [NCH-1:0][RW-1:0] r,
  output logic [CW-1:0]          core
);

  logic [NCH-1:0][CW-1:0] term;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_term
    localparam logic [CW-1:0] K_C = CW'(BASIS_CORE[ch]);
    assign term[ch] = CW'(r[ch]) * K_C;
  end

  always_comb begin
    core = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      core = core + term[ch];
    end
  end

endmodule

// File: rtl/rns_operand_fold.sv
// Sign detection against the range midpoint and selection of the magnitude.
module rns_operand_fold #(
  parameter int unsigned NCH      = 4,
  parameter int unsigned RW       = 5,
  parameter int unsigned CW       = 17,
  parameter int unsigned REF_CH   = 0,
  parameter int unsigned MODULI     [NCH] = '{11, 13, 17, 19},
  parameter int unsigned BASIS_CORE [NCH] = '{83408, 100824, 84811, 124173},
  parameter int unsigned MID_CORE = 65517,
  parameter int unsigned MID_RES  = 5
) (
  input  logic [NCH-1:0][RW-1:0] x,
  output logic                   is_neg,
  output logic [NCH-1:0][RW-1:0] mag,
  output logic [CW-1:0]          mag_core
);
  import rns_sign_pkg::*;

  localparam logic [CW-1:0] MID_CORE_C = CW'(MID_CORE);
  localparam logic [RW-1:0] MID_RES_C  = RW'(MID_RES);

  logic [NCH-1:0][RW-1:0] x_neg;
  logic [CW-1:0]          x_core;
  logic [CW-1:0]          x_neg_core;
  ord_e                   vs_mid;

  rns_negate #(.NCH(NCH), .RW(RW), .MODULI(MODULI)) u_neg (
    .r   (x),
    .neg (x_neg)
  );

  rns_core_eval #(.NCH(NCH), .RW(RW), .CW(CW), .BASIS_CORE(BASIS_CORE)) u_core_pos (
    .r    (x),
    .core (x_core)
  );

  rns_core_eval #(.NCH(NCH), .RW(RW), .CW(CW), .BASIS_CORE(BASIS_CORE)) u_core_neg (
    .r    (x_neg),
    .core (x_neg_core)
  );

  rns_order_cmp #(.CW(CW), .RW(RW)) u_mid_cmp (
    .a_core (x_core),
    .a_tie  (x[REF_CH]),
    .b_core (MID_CORE_C),
    .b_tie  (MID_RES_C),
    .rel    (vs_mid)
  );

  always_comb begin
    is_neg   = (vs_mid == ORD_GT);
    mag      = is_neg ? x_neg      : x;
    mag_core = is_neg ? x_neg_core : x_core;
  end

endmodule

// File: rtl/rns_sign_classifier.sv
module rns_sign_classifier #(
  parameter int unsigned NCH      = 4,
  parameter int unsigned RW       = 5,
  parameter int unsigned CW       = 17,
  parameter int unsigned REF_CH   = 0,
  parameter int unsigned MODULI     [NCH] = '{11, 13, 17, 19},
  parameter int unsigned BASIS_CORE [NCH] = '{83408, 100824, 84811, 124173},
  parameter int unsigned MID_CORE = 65517,
  parameter int unsigned MID_RES  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [NCH*RW-1:0]   dividend,
  input  logic [NCH*RW-1:0]   divisor,
  output logic                out_valid,
  output logic                res_neg,
  output logic                dvd_neg,
  output logic                dvs_neg,
  output logic                q_zero,
  output logic                q_unit,
  output logic [NCH*RW-1:0]   abs_dividend,
  output logic [CW-1:0]       abs_dividend_core,
  output logic [NCH*RW-1:0]   abs_divisor
);
  import rns_sign_pkg::*;

  localparam int unsigned VW = NCH * RW;

  typedef struct packed {
    logic          res_neg;
    logic          dvd_neg;
    logic          dvs_neg;
    logic          q_zero;
    logic          q_unit;
    logic [VW-1:0] a_mag;
    logic [CW-1:0] a_core;
    logic [VW-1:0] b_mag;
  } result_t;

  logic [NCH-1:0][RW-1:0] a_in, b_in, a_mag, b_mag;
  logic [CW-1:0]          a_core, b_core;
  logic                   a_neg, b_neg;
  ord_e                   mag_rel;
  result_t                res_q, res_d;
  logic                   vld_q, vld_d;

  assign a_in = dividend;
  assign b_in = divisor;

  rns_operand_fold #(
    .NCH(NCH), .RW(RW), .CW(CW), .REF_CH(REF_CH), .MODULI(MODULI),
    .BASIS_CORE(BASIS_CORE), .MID_CORE(MID_CORE), .MID_RES(MID_RES)
  ) u_fold_dvd (
    .x        (a_in),
    .is_neg   (a_neg),
    .mag      (a_mag),
    .mag_core (a_core)
  );

  rns_operand_fold #(
    .NCH(NCH), .RW(RW), .CW(CW), .REF_CH(REF_CH), .MODULI(MODULI),
    .BASIS_CORE(BASIS_CORE), .MID_CORE(MID_CORE), .MID_RES(MID_RES)
  ) u_fold_dvs (
    .x        (b_in),
    .is_neg   (b_neg),
    .mag      (b_mag),
    .mag_core (b_core)
  );

  rns_order_cmp #(.CW(CW), .RW(RW)) u_mag_cmp (
    .a_core (a_core),
    .a_tie  (a_mag[REF_CH]),
    .b_core (b_core),
    .b_tie  (b_mag[REF_CH]),
    .rel    (mag_rel)
  );

  // Next-state: capture enabled by in_valid, otherwise hold.
  always_comb begin
    res_d = res_q;
    vld_d = in_valid;
    if (in_valid) begin
      res_d.res_neg = a_neg ^ b_neg;
      res_d.dvd_neg = a_neg;
      res_d.dvs_neg = b_neg;
      res_d.q_zero  = (mag_rel == ORD_LT);
      res_d.q_unit  = (mag_rel == ORD_EQ);
      res_d.a_mag   = a_mag;
      res_d.a_core  = a_core;
      res_d.b_mag   = b_mag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign out_valid         = vld_q;
  assign res_neg           = res_q.res_neg;
  assign dvd_neg           = res_q.dvd_neg;
  assign dvs_neg           = res_q.dvs_neg;
  assign q_zero            = res_q.q_zero;
  assign q_unit            = res_q.q_unit;
  assign abs_dividend      = res_q.a_mag;
  assign abs_dividend_core = res_q.a_core;
  assign abs_divisor       = res_q.b_mag;

endmodule

// File: rtl/rns_sign_classifier_chk.sv
module rns_sign_classifier_chk #(
  parameter int unsigned NCH      = 4,
  parameter int unsigned RW       = 5,
  parameter int unsigned CW       = 17,
  parameter int unsigned MODULI [NCH] = '{11, 13, 17, 19},
  parameter int unsigned MID_CORE = 65517
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [NCH*RW-1:0] dividend,
  input logic              out_valid,
  input logic              dvd_neg,
  input logic              q_zero,
  input logic              q_unit,
  input logic [NCH*RW-1:0] abs_dividend,
  input logic [CW-1:0]     abs_dividend_core,
  input logic [NCH*RW-1:0] abs_divisor
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_rng
    p_mag_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      abs_dividend[ch*RW +: RW] < RW'(MODULI[ch]) &&
      abs_divisor[ch*RW +: RW]  < RW'(MODULI[ch]));
  end

  // R2: a magnitude never ranks above the midpoint.
  p_core_le_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abs_dividend_core <= CW'(MID_CORE));

  p_pos_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (dvd_neg || abs_dividend == $past(dividend)));

  p_unit_same_mag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_unit |-> (abs_dividend == abs_divisor));

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_zero && q_unit));

  p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(abs_dividend) && $stable(abs_divisor) &&
                   $stable(q_zero) && $stable(q_unit) && $stable(dvd_neg)));

endmodule

bind rns_sign_classifier rns_sign_classifier_chk #(
  .NCH(NCH), .RW(RW), .CW(CW), .MODULI(MODULI), .MID_CORE(MID_CORE)
) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .in_valid          (in_valid),
  .dividend          (dividend),
  .out_valid         (out_valid),
  .dvd_neg           (dvd_neg),
  .q_zero            (q_zero),
  .q_unit            (q_unit),
  .abs_dividend      (abs_dividend),
  .abs_dividend_core (abs_dividend_core),
  .abs_divisor       (abs_divisor)
);

// File: tb/tb_rns_sign_classifier.sv
`timescale 1ns/1ps
module tb_rns_sign_classifier;

  localparam int NCH = 4;
  localparam int RW  = 5;
  localparam int CW  = 17;
  localparam int MODS [NCH] = '{11, 13, 17, 19};
  localparam int WTS  [NCH] = '{16, 8, 5, 9};
  localparam int M    = 11 * 13 * 17 * 19;
  localparam int H    = (M - 1) / 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [NCH*RW-1:0] dividend, divisor;
  logic              out_valid, res_neg, dvd_neg, dvs_neg, q_zero, q_unit;
  logic [NCH*RW-1:0] abs_dividend, abs_divisor;
  logic [CW-1:0]     abs_dividend_core;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rns_sign_classifier dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .dividend(dividend), .divisor(divisor),
    .out_valid(out_valid), .res_neg(res_neg), .dvd_neg(dvd_neg),
    .dvs_neg(dvs_neg), .q_zero(q_zero), .q_unit(q_unit),
    .abs_dividend(abs_dividend), .abs_dividend_core(abs_dividend_core),
    .abs_divisor(abs_divisor)
  );

  function automatic logic [NCH*RW-1:0] to_rns(int x);
    logic [NCH*RW-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*RW +: RW] = RW'(x % MODS[i]);
    return v;
  endfunction

  function automatic int mag_of(int x);
    return (x > H) ? M - x : x;
  endfunction

  function automatic int core_of(int a);
    int c = 0;
    for (int i = 0; i < NCH; i++) c += WTS[i] * (a / MODS[i]);
    return c;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, wait one cycle, check registered result.
  task automatic run_pair(input int x, input int y);
    int ax, ay;
    dividend = to_rns(x);
    divisor  = to_rns(y);
    in_valid = 1'b1;
    @(negedge clk);
    ax = mag_of(x);
    ay = mag_of(y);
    chk("R8 out_valid", out_valid, 1);
    chk("R3 dvd_neg", dvd_neg, (x > H) ? 1 : 0);
    chk("R3 dvs_neg", dvs_neg, (y > H) ? 1 : 0);
    chk("R4 res_neg", res_neg, ((x > H) != (y > H)) ? 1 : 0);
    if (x > H) chk("R1 abs_dividend", abs_dividend, to_rns(ax));
    else       chk("R5 abs_dividend", abs_dividend, to_rns(ax));
    if (y > H) chk("R1 abs_divisor", abs_divisor, to_rns(ay));
    else       chk("R5 abs_divisor", abs_divisor, to_rns(ay));
    chk("R2 core", abs_dividend_core, core_of(ax));
    chk("R6 q_zero", q_zero, (ax < ay) ? 1 : 0);
    chk("R7 q_unit", q_unit, (ax == ay) ? 1 : 0);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    dividend = '0;
    divisor  = '0;
    repeat (3) @(negedge clk);
    chk("R10 out_valid", out_valid, 0);
    chk("R10 q_zero", q_zero, 0);
    chk("R10 q_unit", q_unit, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid idle", out_valid, 0);

    // Boundary pairs around the midpoint, zero and the top of the range.
    run_pair(H, H + 1);
    run_pair(H + 1, H);
    run_pair(0, 0);
    run_pair(0, 5);
    run_pair(M - 1, 1);
    run_pair(M - 11, 11);
    run_pair(1, M - 1);

    // Every dividend value once, scrambled divisor.
    for (int x = 0; x < M; x++) run_pair(x, (x * 7919 + 5) % M);

    // Magnitude ordering: equal, opposite sign, off by one each way.
    for (int a = 0; a <= H; a += 11) begin
      run_pair(a, a);
      run_pair((M - a) % M, a);
      run_pair(a, (a + 1) % M);
      run_pair((a + 1) % M, (M - a) % M);
    end

    // R9: idle with changing operands, last result must hold.
    run_pair(M - 7, 3);
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      dividend = to_rns(100 + k);
      divisor  = to_rns(M - 200 - k);
      @(negedge clk);
      chk("R8 out_valid low", out_valid, 0);
      chk("R9 abs_dividend hold", abs_dividend, to_rns(7));
      chk("R9 abs_divisor hold", abs_divisor, to_rns(3));
      chk("R9 q_zero hold", q_zero, 0);
      chk("R9 dvd_neg hold", dvd_neg, 1);
      chk("R9 core hold", abs_dividend_core, core_of(7));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule